// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with One-Time Lockable Region

This block is a synthesizable slave for a two-wire serial bus that fronts a byte-wide memory held in an on-chip register array. The bus lines are sampled in the system clock domain. Start and stop conditions are recognised, and a select byte is matched against two strap inputs, so up to four such slaves can share one bus. A write transaction carries a two-byte word address and then any number of data bytes, which fill the current 64-byte page. A read transaction uses the stored address and continues byte after byte until the master withholds its acknowledge.

A write-protect input blocks every write. The lowest 256 bytes of the array form a region that acts as ordinary memory until a one-time lock command is accepted. After that the region stays read-only until reset. Each completed write starts an internal write cycle of `WR_CYCLES` clocks, and `busy_o` shows that cycle. While it runs, the slave ignores its select byte. The array holds 2^`ADDR_W` bytes. The default `ADDR_W` is 11 to keep elaboration small, and `ADDR_W = 15` gives the full 32,768-byte, 512-page array.

Top module: `i2c_otp_eeprom`

## Requirements
- R1: A falling SDA while SCL is high (start) aborts any transaction in progress and waits for a select byte. A rising SDA while SCL is high (stop) returns the slave to idle.
- R2: The slave changes its SDA drive only while SCL is low. It pulls SDA low through the ninth clock after each byte it accepts.
- R3: A select byte is acknowledged only in two cases. The first is bits[7:4] = 1010 with bits[2:1] equal to `strap_i`; bit 3 is ignored and bit 0 = 1 means read. The second is bits[7:4] = 1011, the same strap match, and bit 0 = 0. Every other select byte is not acknowledged.
- R4: After a write select, the first byte is the high byte of the address and the second byte is the low byte. Only the low `ADDR_W` bits are kept. A read select returns the byte at the stored address, MSB first.
- R5: Each data byte of a write is stored at the current address. Only the low 6 address bits then increment, wrapping within the 64-byte page.
- R6: A read advances the full address after each byte and rolls over from the last location to 0. The read continues while the master acknowledges and ends when it does not.
- R7: While `wp_i` is high, data bytes are still acknowledged, the memory is unchanged and no write cycle starts.
- R8: The lock command is select byte 1011 x A1 A0 0 followed by data byte 0xA5, sent while `wp_i` is low. It locks addresses 0x000–0x0FF against writes permanently. Blocked writes are acknowledged and start no write cycle. Before the lock, that region is writable, and the lock leaves other addresses writable.
- R9: A stop after a transaction that changed memory or set the lock holds `busy_o` high for exactly `WR_CYCLES` clocks. A select byte received during that time is not acknowledged.
- R10: After reset, SDA is released and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| strap_i | input | 2 | Device address straps matched against select bits [2:1] |
| wp_i | input | 1 | Write protect, high blocks all writes; tie low if unused |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
Page writes are tried both within a page and across the page end. The wrapping case separates page-local increment from full-address increment, and a sequential read across the top of the array shows the opposite rule for reads. Select bytes with a wrong strap, a set don't-care bit, an unknown type code and a read of the lock type show which fields the match actually decodes. Writes are sent with protect high, into the lockable region before and after locking, and outside it after locking, and each is read back. Together with `busy_o`, these reads tell blocked writes apart from accepted ones. A lock command sent under protect is then shown to have no effect by a later successful write to the region.

// File: rtl/i2c_otp_pkg.sv
package i2c_otp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_LOCK, ST_RD
  } ee_state_t;
  localparam logic [3:0] TYPE_MEM  = 4'hA;
  localparam logic [3:0] TYPE_LOCK = 4'hB;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_N-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_N-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_N-2:0], sda_i};
      scl_p    <= scl_pipe[SYNC_N-1];
      sda_p    <= sda_pipe[SYNC_N-1];
    end
  end

  assign scl_s    = scl_pipe[SYNC_N-1];
  assign sda_s    = sda_pipe[SYNC_N-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // SDA moving while SCL stays high is a bus condition (R1)
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start_i)    cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);

  // a new cycle can only be requested by a transaction that began while idle (R9)
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/i2c_otp_eeprom.sv
module i2c_otp_eeprom
  import i2c_otp_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int          PAGE_W    = 6,
  parameter int          OTP_W     = 8,
  parameter int          WR_CYCLES = 200,
  parameter logic [7:0]  LOCK_KEY  = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] strap_i,
  input  logic       wp_i,
  output logic       busy_o
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    page_next = {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    seq_next = a + ADDR_W'(1);
  endfunction

  function automatic logic in_otp(input logic [ADDR_W-1:0] a);
    in_otp = (a[ADDR_W-1:OTP_W] == '0);
  endfunction

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  i2c_line_mon #(.SYNC_N(2)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  ee_state_t         st, nxt_q, nxt_c;
  logic [3:0]        bitcnt;
  logic              ack_ph, mack, wr_pend, otp_lock, ack_c;
  logic [7:0]        sr, out_sr, ahi;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        mem [DEPTH];
  logic [15:0]       addr16;

  // named events for the assertions and the bench's reasoning
  logic rx_state, byte_rx, dev_ok, wr_allowed, mem_we, lock_set, wr_start;
  assign rx_state   = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) ||
                      (st == ST_WDAT) || (st == ST_LOCK);
  assign byte_rx    = rx_state && scl_fall && (bitcnt == 4'd8) && !ack_ph;
  assign dev_ok     = !busy_o && (sr[2:1] == strap_i) &&
                      ((sr[7:4] == TYPE_MEM) || (sr[7:4] == TYPE_LOCK && !sr[0]));
  assign wr_allowed = !wp_i && !(otp_lock && in_otp(ptr));
  assign mem_we     = byte_rx && (st == ST_WDAT) && wr_allowed;
  assign lock_set   = byte_rx && (st == ST_LOCK) && (sr == LOCK_KEY) && !wp_i && !otp_lock;
  assign wr_start   = stop_ev && wr_pend;
  assign addr16     = {ahi, sr};

  always_comb begin
    ack_c = 1'b1;
    nxt_c = st;
    case (st)
      ST_DEV: begin
        ack_c = dev_ok;
        if (!dev_ok)       nxt_c = ST_IDLE;
        else if (sr[0])    nxt_c = ST_RD;
        else if (sr[7:4] == TYPE_MEM) nxt_c = ST_AHI;
        else               nxt_c = ST_LOCK;
      end
      ST_AHI:  nxt_c = ST_ALO;
      ST_ALO:  nxt_c = ST_WDAT;
      default: nxt_c = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr] <= sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt_q <= ST_IDLE; bitcnt <= '0; ack_ph <= 1'b0;
      mack <= 1'b0; wr_pend <= 1'b0; otp_lock <= 1'b0; sda_oe_o <= 1'b0;
      sr <= '0; out_sr <= '0; ahi <= '0; ptr <= '0;
    end else if (start_ev) begin
      st <= ST_DEV; bitcnt <= '0; ack_ph <= 1'b0; sda_oe_o <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; bitcnt <= '0; ack_ph <= 1'b0; sda_oe_o <= 1'b0;
      wr_pend <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise && !ack_ph && bitcnt < 4'd8) begin
        sr     <= {sr[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end
      if (byte_rx) begin
        ack_ph   <= 1'b1;
        sda_oe_o <= ack_c;
        nxt_q    <= nxt_c;
        if (st == ST_AHI)  ahi <= sr;
        if (st == ST_ALO)  ptr <= addr16[ADDR_W-1:0];
        if (st == ST_WDAT) ptr <= page_next(ptr);
        if (mem_we || lock_set) wr_pend <= 1'b1;
        if (lock_set) otp_lock <= 1'b1;
      end else if (scl_fall && ack_ph) begin
        ack_ph <= 1'b0;
        bitcnt <= '0;
        st     <= nxt_q;
        if (nxt_q == ST_RD) begin
          sda_oe_o <= ~mem[ptr][7];
          out_sr   <= {mem[ptr][6:0], 1'b0};
        end else begin
          sda_oe_o <= 1'b0;
        end
      end
    end else if (st == ST_RD) begin
      if (scl_rise) begin
        if (ack_ph)                mack   <= ~sda_s;
        else if (bitcnt < 4'd8)    bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall) begin
        if (ack_ph) begin
          ack_ph <= 1'b0;
          bitcnt <= '0;
          if (mack) begin
            sda_oe_o <= ~mem[ptr][7];
            out_sr   <= {mem[ptr][6:0], 1'b0};
          end else begin
            st       <= ST_IDLE;
            sda_oe_o <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          sda_oe_o <= 1'b0;
          ack_ph   <= 1'b1;
          ptr      <= seq_next(ptr);
        end else if (bitcnt != 4'd0) begin
          sda_oe_o <= ~out_sr[7];
          out_sr   <= {out_sr[6:0], 1'b0};
        end
      end
    end
  end

  eeprom_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(wr_start), .busy_o(busy_o)
  );

  // R2: drive changes only land while the sampled clock line is low
  p_sda_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);
  // R9: a select byte seen during a write cycle is left unacknowledged
  p_busy_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rx && st == ST_DEV && busy_o) |=> !sda_oe_o);
  // R7: no array write while protect is high
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp_i);
  // R5: page number is kept across data bytes
  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rx && st == ST_WDAT) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
  // R8: once set, the lock never clears
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    otp_lock |=> otp_lock);
endmodule

// File: tb/i2c_otp_eeprom_tb.sv
module i2c_otp_eeprom_tb;
  localparam int WRC = 600;
  localparam int Q = 6;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wp = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_oe, busy;
  logic sda_line;
  int checks = 0, fails = 0, busy_cycles = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_otp_eeprom #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .wp_i(wp), .busy_o(busy)
  );

  always @(negedge clk) if (busy) busy_cycles++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2);
    ack = ~sda_line; tick(H/2); m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(H/2); d[i] = sda_line; tick(H/2); m_scl = 1'b0;
    end
    m_sda = last; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q); m_sda = 1'b1;
  endtask

  task automatic wait_ready;
    int n = 0;
    while (busy && n < 4*WRC) begin tick(1); n++; end
  endtask

  // write n bytes from wbuf at addr; every byte expected to be acknowledged (R2)
  task automatic write_bytes(input string req, input logic [15:0] addr, input int n);
    logic a;
    bus_start;
    send_byte(8'hA4, a); check({req, " select ack"}, a, 1);
    send_byte(addr[15:8], a); check({req, " addr hi ack R4"}, a, 1);
    send_byte(addr[7:0], a);  check({req, " addr lo ack R4"}, a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); check({req, " data ack R2"}, a, 1);
    end
    bus_stop;
  endtask

  task automatic read_bytes(input logic [15:0] addr, input int n);
    logic a;
    bus_start;
    send_byte(8'hA4, a); send_byte(addr[15:8], a); send_byte(addr[7:0], a);
    bus_start;  // repeated start aborts the write and reselects (R1)
    send_byte(8'hA5, a); check("R1 reselect after repeated start", a, 1);
    for (int k = 0; k < n; k++) recv_byte(k == n-1, rbuf[k]);
    bus_stop;
  endtask

  task automatic t_reset;
    check("R10 sda released", sda_oe, 0);
    check("R10 busy low", busy, 0);
  endtask

  task automatic t_page_write;
    logic a;
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    busy_cycles = 0;
    write_bytes("R5", 16'h0140, 3);
    check("R9 busy after write", busy, 1);
    bus_start; send_byte(8'hA4, a); bus_stop;
    check("R9 select nacked while busy", a, 0);
    wait_ready; tick(2);
    check("R9 busy length", busy_cycles, WRC);
    read_bytes(16'h0140, 3);
    check("R4 read 0x140", rbuf[0], 8'hAA);
    check("R5 read 0x141", rbuf[1], 8'hBB);
    check("R5 read 0x142", rbuf[2], 8'hCC);
  endtask

  task automatic t_page_wrap;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    write_bytes("R5 wrap", 16'h017E, 4); wait_ready;
    read_bytes(16'h017E, 2);
    check("R5 0x17E", rbuf[0], 8'h11);
    check("R5 0x17F", rbuf[1], 8'h22);
    read_bytes(16'h0140, 3);
    check("R5 wrapped 0x140", rbuf[0], 8'h33);
    check("R5 wrapped 0x141", rbuf[1], 8'h44);
    check("R5 untouched 0x142", rbuf[2], 8'hCC);
    read_bytes(16'h7940, 1);  // address bits above ADDR_W=11 dropped
    check("R4 upper address bits ignored", rbuf[0], 8'h33);
  endtask

  task automatic t_rollover;
    wbuf[0] = 8'h5A; write_bytes("R6", 16'h07FF, 1); wait_ready;
    wbuf[0] = 8'h77; write_bytes("R6", 16'h0000, 1); wait_ready;
    read_bytes(16'h07FF, 2);
    check("R6 last location", rbuf[0], 8'h5A);
    check("R6 rolls to 0", rbuf[1], 8'h77);
  endtask

  task automatic t_select;
    logic a;
    bus_start; send_byte(8'hA0, a); bus_stop; check("R3 wrong strap nack", a, 0);
    bus_start; send_byte(8'hAC, a); bus_stop; check("R3 bit3 don't care ack", a, 1);
    bus_start; send_byte(8'h94, a); bus_stop; check("R3 unknown type nack", a, 0);
    bus_start; send_byte(8'hB5, a); bus_stop; check("R3 lock-type read nack", a, 0);
    tick(4); check("R9 no busy from empty writes", busy, 0);
  endtask

  task automatic t_wp;
    wbuf[0] = 8'h12; write_bytes("R7 setup", 16'h0200, 1); wait_ready;
    wp = 1'b1; wbuf[0] = 8'h99; write_bytes("R7", 16'h0200, 1);
    tick(4); check("R7 no write cycle", busy, 0);
    wp = 1'b0;
    read_bytes(16'h0200, 1); check("R7 memory unchanged", rbuf[0], 8'h12);
  endtask

  task automatic t_lock;
    logic a;
    wbuf[0] = 8'h3C; write_bytes("R8 prelock", 16'h0010, 1); wait_ready;
    read_bytes(16'h0010, 1); check("R8 region writable before lock", rbuf[0], 8'h3C);
    wp = 1'b1;
    bus_start; send_byte(8'hB4, a); send_byte(8'hA5, a); bus_stop;
    tick(4); check("R8 lock under WP ignored, no busy", busy, 0);
    wp = 1'b0;
    wbuf[0] = 8'h3D; write_bytes("R8 still open", 16'h0010, 1); wait_ready;
    read_bytes(16'h0010, 1); check("R8 region still writable", rbuf[0], 8'h3D);
    bus_start; send_byte(8'hB4, a); check("R8 lock select ack", a, 1);
    send_byte(8'hA5, a); check("R8 key ack", a, 1); bus_stop;
    check("R8 lock starts write cycle", busy, 1); wait_ready;
    wbuf[0] = 8'hEE; write_bytes("R8 locked", 16'h0010, 1);
    tick(4); check("R8 blocked write no busy", busy, 0);
    read_bytes(16'h0010, 1); check("R8 locked region unchanged", rbuf[0], 8'h3D);
    wbuf[0] = 8'h4D; write_bytes("R8 outside", 16'h0300, 1); wait_ready;
    read_bytes(16'h0300, 1); check("R8 outside region writable", rbuf[0], 8'h4D);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset;
    t_page_write;
    t_page_wrap;
    t_rollover;
    t_select;
    t_wp;
    t_lock;
    report;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report;
  end
endmodule